// File: doc/BRIEF.md
# Clock Generator Sequencer with Aligned Dividers

This block controls a clock-generation subsystem built around an external analog PLL. It drives the PLL's reset and enable pins and sequences power-up and reconfiguration. The reset pin is held for a minimum time, and then the block waits for lock for a minimum time before it raises enable. While enable is low the subsystem runs in bypass. A small write/read register interface holds the input pre-divider, the feedback multiplier and three output post-dividers.

The block produces three clock-enable outputs, which are single-cycle pulses at the programmed divide ratios. New post-divider values are only staged. They take effect on an explicit go command, which first checks that the ratio between the first two outputs is legal. An accepted go restarts all three outputs in phase and pulses a reset to the downstream bus bridge. A write to the pre-divider or the multiplier also pulses the bridge reset, drops back to bypass and restarts the lock wait. A status flag reports when the programmed pre-divider and multiplier would put the PLL input or output frequency outside its legal window, using a reference-frequency parameter.

Register map (write and read share it): address 0 holds the pre-divider field, where ratio = field + 1 and the reset field is 1. Address 1 holds the multiplier value, 4 to 25, with reset value 13. Addresses 2, 3 and 4 hold the pending post-divider fields for outputs 0, 1 and 2, where ratio = field + 1 and the reset fields are 0, 1 and 2. Address 5 is the command register: writing bit 0 set issues go. Address 6 is the alignment control, which always reads 0x07. All other addresses read 0.

Top module: `plls_ctrl`

## Requirements
- R1: After reset is released, `pll_rst_o` stays high for exactly RST_CYC cycles, where RST_CYC = ceil(RST_NS × CLK_KHZ / 10^6) and is 7 by default. `pll_en_o` is never high while `pll_rst_o` is high.
- R2: After the reset hold, `pll_en_o` rises only after LOCK_CYC cycles of lock wait, where LOCK_CYC = ceil(LOCK_US_X10 × CLK_KHZ / 10^4) and is 9375 by default. `busy_o` is high throughout the hold and the wait. `bypass_o` is the inverse of `pll_en_o`.
- R3: A multiplier write (address 1) with data from 4 to 25 is stored and clears `reject_o`. Any other value sets `reject_o` and keeps the old value. The reset value is 13.
- R4: Out of reset the post-divider ratios are 1, 2 and 3 (fields 0, 1, 2). All three enables pulse in the first cycle after reset release, and output i then pulses whenever the cycle count since release is a multiple of its ratio.
- R5: On go, if the pending ratio of output 1 is not exactly 2, 3 or 4 times the pending ratio of output 0, `reject_o` is set and the active ratios and phases are unchanged. An accepted go clears `reject_o`.
- R6: Writes to addresses 2 to 4 read back at once, but they do not change the enable pattern until a go is accepted.
- R7: An accepted go makes the pending ratios active. In the next cycle all three enables are high together and `bridge_rst_o` is high for that one cycle. From then on, output i pulses every ratio(i) cycles.
- R8: Address 6 always reads 0x07, and writes to it are ignored.
- R9: An accepted write to address 0 or 1 pulses `bridge_rst_o` in the next cycle, drops `pll_en_o` (bypass) and restarts the full LOCK_CYC wait.
- R10: `freq_err_o` is high when REF_KHZ / pre-ratio is outside 12000 to 50000 kHz, or when (REF_KHZ / pre-ratio) × multiplier is outside 140000 to 600000 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL output / reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| pll_rst_o | output | 1 | PLL reset control |
| pll_en_o | output | 1 | PLL enable (low = bypass) |
| bypass_o | output | 1 | Bypass active |
| busy_o | output | 1 | Hold, lock wait or go cycle in progress |
| bridge_rst_o | output | 1 | One-cycle downstream bridge reset |
| clk_en_o | output | 3 | Divided clock-enable pulses |
| reject_o | output | 1 | Last multiplier write or go was rejected |
| freq_err_o | output | 1 | Pre-divided input or PLL output out of range |

## Verification
The hardest situation to reach is a go issued in the middle of a running divider pattern that has an arbitrary phase, with legal and illegal ratio pairs interleaved. After an illegal go the old phase must carry on untouched, and after a legal one every output must realign at once. The bench tracks the phase of each output with its own cycle counter. It issues go commands from random pending fields, drawing the ratio of output 1 as a random multiple of 1 to 5 of the ratio of output 0 so that both legal and illegal pairs come up often. It compares every enable on every cycle. Relock is reached by writing the multiplier while enabled and timing the full lock wait again.

// File: rtl/plls_pkg.sv
package plls_pkg;
    localparam int NUM_OUT = 3;

    localparam logic [2:0] A_PRE   = 3'd0;
    localparam logic [2:0] A_MUL   = 3'd1;
    localparam logic [2:0] A_POST0 = 3'd2;
    localparam logic [2:0] A_CMD   = 3'd5;
    localparam logic [2:0] A_ALN   = 3'd6;

    localparam int DEF_PRE_FLD = 1;
    localparam int DEF_MUL     = 13;
    localparam int MUL_MIN     = 4;
    localparam int MUL_MAX     = 25;

    localparam int FIN_MIN_KHZ  = 12000;
    localparam int FIN_MAX_KHZ  = 50000;
    localparam int FOUT_MIN_KHZ = 140000;
    localparam int FOUT_MAX_KHZ = 600000;

    typedef enum logic [1:0] {
        SQ_HOLD = 2'd0,
        SQ_LOCK = 2'd1,
        SQ_RUN  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/plls_seq.sv
module plls_seq
    import plls_pkg::*;
#(
    parameter int RST_CYC  = 7,
    parameter int LOCK_CYC = 9375
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic relock_i,
    output logic pll_rst_o,
    output logic pll_en_o
);
    localparam int MAX_CYC = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            SQ_HOLD: begin
                if (q.cnt == CNT_W'(RST_CYC - 1)) begin
                    d.st  = SQ_LOCK;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_LOCK: begin
                if (relock_i) begin
                    d.cnt = '0;
                end else if (q.cnt == CNT_W'(LOCK_CYC - 1)) begin
                    d.st  = SQ_RUN;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_RUN: begin
                if (relock_i) begin
                    d.st  = SQ_LOCK;
                    d.cnt = '0;
                end
            end
            default: begin
                d.st  = SQ_HOLD;
                d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st  <= SQ_HOLD;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign pll_rst_o = (q.st == SQ_HOLD);
    assign pll_en_o  = (q.st == SQ_RUN);
endmodule

// File: rtl/plls_div.sv
module plls_div #(
    parameter int FLD_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [FLD_W-1:0] ratio_m1_i,
    input  logic             restart_i,
    output logic             en_o
);
    typedef struct packed {
        logic [FLD_W-1:0] cnt;
    } div_t;

    div_t q, d;

    always_comb begin
        d = q;
        if (restart_i || (q.cnt >= ratio_m1_i)) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign en_o = (q.cnt == '0);
endmodule

// File: rtl/plls_cfg.sv
module plls_cfg
    import plls_pkg::*;
#(
    parameter int FLD_W   = 5,
    parameter int REF_KHZ = 50000
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [2:0]                      wr_addr_i,
    input  logic [7:0]                      wr_data_i,
    input  logic [2:0]                      rd_addr_i,
    output logic [7:0]                      rd_data_o,
    output logic [NUM_OUT-1:0][FLD_W-1:0]   act_o,
    output logic                            restart_o,
    output logic                            relock_o,
    output logic                            bridge_rst_o,
    output logic                            reject_o,
    output logic                            freq_err_o
);
    localparam int RW = FLD_W + 3;

    typedef struct packed {
        logic [FLD_W-1:0]                    pre;
        logic [FLD_W-1:0]                    mul;
        logic [NUM_OUT-1:0][FLD_W-1:0]       pend;
        logic [NUM_OUT-1:0][FLD_W-1:0]       act;
        logic                                reject;
        logic                                brst;
    } cfg_t;

    function automatic cfg_t reset_val();
        cfg_t v;
        v.pre    = FLD_W'(DEF_PRE_FLD);
        v.mul    = FLD_W'(DEF_MUL);
        for (int i = 0; i < NUM_OUT; i++) begin
            v.pend[i] = FLD_W'(i);
            v.act[i]  = FLD_W'(i);
        end
        v.reject = 1'b0;
        v.brst   = 1'b0;
        return v;
    endfunction

    cfg_t q, d;
    logic go_ok, relock;
    logic [RW-1:0] r0, r1;
    logic ratio_ok;

    // Ratio legality of staged outputs 0 and 1
    always_comb begin
        r0 = RW'(q.pend[0]) + 1'b1;
        r1 = RW'(q.pend[1]) + 1'b1;
        ratio_ok = (r1 == (r0 << 1)) || (r1 == (r0 + (r0 << 1))) || (r1 == (r0 << 2));
    end

    always_comb begin
        d      = q;
        d.brst = 1'b0;
        go_ok  = 1'b0;
        relock = 1'b0;
        if (wr_en_i) begin
            if (wr_addr_i == A_PRE) begin
                d.pre  = wr_data_i[FLD_W-1:0];
                relock = 1'b1;
            end else if (wr_addr_i == A_MUL) begin
                if (wr_data_i >= 8'(MUL_MIN) && wr_data_i <= 8'(MUL_MAX)) begin
                    d.mul    = wr_data_i[FLD_W-1:0];
                    d.reject = 1'b0;
                    relock   = 1'b1;
                end else begin
                    d.reject = 1'b1;
                end
            end else if (wr_addr_i == A_CMD) begin
                if (wr_data_i[0]) begin
                    if (ratio_ok) begin
                        go_ok    = 1'b1;
                        d.act    = q.pend;
                        d.reject = 1'b0;
                    end else begin
                        d.reject = 1'b1;
                    end
                end
            end else begin
                for (int i = 0; i < NUM_OUT; i++) begin
                    if (wr_addr_i == 3'(int'(A_POST0) + i)) begin
                        d.pend[i] = wr_data_i[FLD_W-1:0];
                    end
                end
            end
        end
        d.brst = go_ok | relock;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= reset_val();
        end else begin
            q <= d;
        end
    end

    // Read mux
    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr_i == A_PRE) begin
            rd_data_o = 8'(q.pre);
        end else if (rd_addr_i == A_MUL) begin
            rd_data_o = 8'(q.mul);
        end else if (rd_addr_i == A_ALN) begin
            rd_data_o = 8'h07;
        end else begin
            for (int i = 0; i < NUM_OUT; i++) begin
                if (rd_addr_i == 3'(int'(A_POST0) + i)) begin
                    rd_data_o = 8'(q.pend[i]);
                end
            end
        end
    end

    // Frequency window check against the reference parameter
    always_comb begin
        int pr;
        int ml;
        pr = int'(q.pre) + 1;
        ml = int'(q.mul);
        freq_err_o = (REF_KHZ < FIN_MIN_KHZ * pr) || (REF_KHZ > FIN_MAX_KHZ * pr) ||
                     (REF_KHZ * ml < FOUT_MIN_KHZ * pr) || (REF_KHZ * ml > FOUT_MAX_KHZ * pr);
    end

    assign act_o        = q.act;
    assign restart_o    = go_ok;
    assign relock_o     = relock;
    assign bridge_rst_o = q.brst;
    assign reject_o     = q.reject;
endmodule

// File: rtl/plls_ctrl.sv
module plls_ctrl
    import plls_pkg::*;
#(
    parameter int CLK_KHZ    = 50000,
    parameter int REF_KHZ    = 50000,
    parameter int RST_NS     = 125,
    parameter int LOCK_US_X10 = 1875,
    parameter int FLD_W      = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_addr_i,
    input  logic [7:0]         wr_data_i,
    input  logic [2:0]         rd_addr_i,
    output logic [7:0]         rd_data_o,
    output logic               pll_rst_o,
    output logic               pll_en_o,
    output logic               bypass_o,
    output logic               busy_o,
    output logic               bridge_rst_o,
    output logic [NUM_OUT-1:0] clk_en_o,
    output logic               reject_o,
    output logic               freq_err_o
);
    localparam int RST_CYC  = (RST_NS * CLK_KHZ + 999999) / 1000000;
    localparam int LOCK_CYC = (LOCK_US_X10 * CLK_KHZ + 9999) / 10000;

    logic [NUM_OUT-1:0][FLD_W-1:0] act;
    logic restart, relock;

    plls_cfg #(.FLD_W(FLD_W), .REF_KHZ(REF_KHZ)) u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .act_o        (act),
        .restart_o    (restart),
        .relock_o     (relock),
        .bridge_rst_o (bridge_rst_o),
        .reject_o     (reject_o),
        .freq_err_o   (freq_err_o)
    );

    plls_seq #(.RST_CYC(RST_CYC), .LOCK_CYC(LOCK_CYC)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .relock_i  (relock),
        .pll_rst_o (pll_rst_o),
        .pll_en_o  (pll_en_o)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
        plls_div #(.FLD_W(FLD_W)) u_div (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ratio_m1_i (act[g]),
            .restart_i  (restart),
            .en_o       (clk_en_o[g])
        );
    end

    assign bypass_o = !pll_en_o;
    assign busy_o   = !pll_en_o || bridge_rst_o;
endmodule

// File: rtl/plls_ctrl_chk.sv
module plls_ctrl_chk
    import plls_pkg::*;
#(
    parameter int RST_CYC  = 7,
    parameter int LOCK_CYC = 9375
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_en_i,
    input logic [2:0]         wr_addr_i,
    input logic [7:0]         wr_data_i,
    input logic [2:0]         rd_addr_i,
    input logic [7:0]         rd_data_o,
    input logic               pll_rst_o,
    input logic               pll_en_o,
    input logic               bypass_o,
    input logic               busy_o,
    input logic               bridge_rst_o,
    input logic [NUM_OUT-1:0] clk_en_o,
    input logic               reject_o
);
    logic [15:0] rst_seen_q, low_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rst_seen_q <= '0;
            low_seen_q <= '0;
        end else begin
            rst_seen_q <= pll_rst_o ? ((rst_seen_q == '1) ? rst_seen_q : rst_seen_q + 1'b1) : '0;
            low_seen_q <= (!pll_en_o && !pll_rst_o) ?
                          ((low_seen_q == '1) ? low_seen_q : low_seen_q + 1'b1) : '0;
        end
    end

    assert_rst_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pll_rst_o) |-> rst_seen_q >= 16'(RST_CYC));

    assert_rst_excl_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pll_rst_o |-> !pll_en_o);

    assert_lock_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pll_en_o) |-> low_seen_q >= 16'(LOCK_CYC));

    assert_idle_running_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (pll_en_o && !bypass_o));

    assert_go_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(wr_en_i && wr_addr_i == A_CMD && wr_data_i[0]) && !reject_o)
        |-> (clk_en_o == '1 && bridge_rst_o));

    assert_align_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == A_ALN) |-> rd_data_o == 8'h07);

    assert_relock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i && wr_addr_i == A_MUL && wr_data_i >= 8'(MUL_MIN) && wr_data_i <= 8'(MUL_MAX))
        |-> (!pll_en_o && bridge_rst_o));
endmodule

bind plls_ctrl plls_ctrl_chk #(.RST_CYC(RST_CYC), .LOCK_CYC(LOCK_CYC)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .pll_rst_o    (pll_rst_o),
    .pll_en_o     (pll_en_o),
    .bypass_o     (bypass_o),
    .busy_o       (busy_o),
    .bridge_rst_o (bridge_rst_o),
    .clk_en_o     (clk_en_o),
    .reject_o     (reject_o)
);

// File: tb/plls_ctrl_tb.sv
module plls_ctrl_tb;
    localparam int REF_KHZ  = 50000;
    localparam int RST_CYC  = 7;
    localparam int LOCK_CYC = 9375;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pll_rst, pll_en, bypass, busy, brst, reject, ferr;
    logic [2:0] clk_en;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    bit trk = 1'b0;
    bit go_hit = 1'b0;
    int ar[3] = '{1, 2, 3};
    string mtag = "R4";

    always #10 clk = ~clk;

    plls_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pll_rst_o(pll_rst), .pll_en_o(pll_en), .bypass_o(bypass), .busy_o(busy),
        .bridge_rst_o(brst), .clk_en_o(clk_en), .reject_o(reject), .freq_err_o(ferr)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_en(int p);
        logic [2:0] e;
        for (int i = 0; i < 3; i++) e[i] = ((p % ar[i]) == 0);
        return e;
    endfunction

    function automatic bit exp_ferr(int pre_fld, int mul);
        int pr = pre_fld + 1;
        return (REF_KHZ < 12000 * pr) || (REF_KHZ > 50000 * pr) ||
               (REF_KHZ * mul < 140000 * pr) || (REF_KHZ * mul > 600000 * pr);
    endfunction

    function automatic bit legal_pair(int f0, int f1);
        int a = f0 + 1;
        int b = f1 + 1;
        return (b == 2 * a) || (b == 3 * a) || (b == 4 * a);
    endfunction

    // One clock: sample 5 ns after the rising edge, check enables against the phase model
    task automatic tick();
        @(posedge clk);
        #5;
        if (go_hit) begin ph = 0; go_hit = 1'b0; end
        else ph++;
        if (trk) chk({mtag, " enable pattern"}, int'(clk_en), int'(exp_en(ph)));
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, int exp, string tag);
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic count_lock(string tag);
        int n = 0;
        bit busy_ok = 1'b1;
        while (!pll_en && n < 20000) begin
            n++;
            if (!busy || !bypass) busy_ok = 1'b0;
            tick();
        end
        chk({tag, " lock wait cycles"}, n, LOCK_CYC);
        chk({tag, " busy/bypass during wait"}, int'(busy_ok), 1);
        chk({tag, " bypass off when enabled"}, int'(bypass), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        int pre_now;
        void'($urandom(32'd7151));
        repeat (4) @(posedge clk);
        #5;
        rst_n = 1'b1;
        ph = 0;
        trk = 1'b1;
        // R4: all enables coincide right after release
        chk("R4 first enables", int'(clk_en), 7);
        rd(3'd0, 1, "R10 pre default");
        rd(3'd1, 13, "R3 mult default");
        rd(3'd2, 0, "R4 post0 default");
        rd(3'd3, 1, "R4 post1 default");
        rd(3'd4, 2, "R4 post2 default");
        chk("R10 freq flag default", int'(ferr), int'(exp_ferr(1, 13)));

        // R1: reset hold length
        n = 0;
        while (pll_rst && n < 100) begin
            n++;
            if (pll_en) chk("R1 enable during hold", 1, 0);
            tick();
        end
        chk("R1 reset hold cycles", n, RST_CYC);
        count_lock("R2");
        tick();
        chk("R2 busy low when running", int'(busy), 0);

        // R9: relock on multiplier write while enabled
        wr(3'd1, 8'd13);
        chk("R9 bridge reset pulse", int'(brst), 1);
        chk("R9 enable dropped", int'(pll_en), 0);
        chk("R9 bypass", int'(bypass), 1);
        count_lock("R9");

        // R3: multiplier range
        wr(3'd1, 8'd3);
        chk("R3 reject below", int'(reject), 1);
        rd(3'd1, 13, "R3 kept after 3");
        wr(3'd1, 8'd26);
        chk("R3 reject above", int'(reject), 1);
        rd(3'd1, 13, "R3 kept after 26");
        wr(3'd1, 8'd4);
        chk("R3 accept 4", int'(reject), 0);
        rd(3'd1, 4, "R3 stored 4");
        wr(3'd1, 8'd200);
        chk("R3 reject 200", int'(reject), 1);
        wr(3'd1, 8'd25);
        rd(3'd1, 25, "R3 stored 25");
        chk("R10 freq 25MHz x25", int'(ferr), int'(exp_ferr(1, 25)));

        // R10: frequency window under several pre/mult pairs
        wr(3'd1, 8'd13);
        foreach (ar[i]) begin end
        for (int p = 0; p < 6; p++) begin
            pre_now = (p == 5) ? 31 : p;
            wr(3'd0, 8'(pre_now));
            chk("R10 freq flag", int'(ferr), int'(exp_ferr(pre_now, 13)));
        end
        wr(3'd1, 8'd4);
        wr(3'd0, 8'd0);
        chk("R10 freq 50MHz x4", int'(ferr), int'(exp_ferr(0, 4)));
        wr(3'd0, 8'd1);
        wr(3'd1, 8'd13);
        chk("R10 freq restored", int'(ferr), 0);
        count_lock("R9 after config");

        // R8: alignment control fixed
        wr(3'd6, 8'h00);
        rd(3'd6, 7, "R8 align readback");
        rd(3'd7, 0, "R8 unused address");

        // Directed go cases
        mtag = "R6";
        wr(3'd2, 8'd0);
        wr(3'd3, 8'd4);
        rd(3'd3, 4, "R6 pending readback");
        mtag = "R5";
        wr(3'd5, 8'd1);
        chk("R5 reject x5", int'(reject), 1);
        chk("R5 no bridge reset", int'(brst), 0);
        wr(3'd3, 8'd0);
        wr(3'd5, 8'd1);
        chk("R5 reject x1", int'(reject), 1);
        wr(3'd3, 8'd3);
        wr(3'd4, 8'd0);
        ar = '{1, 4, 1};
        go_hit = 1'b1;
        mtag = "R7";
        wr(3'd5, 8'd1);
        chk("R7 accept x4", int'(reject), 0);
        chk("R7 bridge reset", int'(brst), 1);
        chk("R7 busy on go", int'(busy), 1);
        tick();
        chk("R7 bridge reset one cycle", int'(brst), 0);

        // Random pending/go sequences
        for (int it = 0; it < 60; it++) begin
            int f0, f1, f2, k, w;
            bit ok;
            f0 = $urandom % 8;
            k = $urandom % 6;
            if (k == 0) f1 = $urandom % 32;
            else begin
                f1 = (f0 + 1) * k - 1;
                if (f1 > 31) f1 = 31;
            end
            f2 = $urandom % 32;
            ok = legal_pair(f0, f1);
            mtag = "R6";
            wr(3'd2, 8'(f0));
            wr(3'd3, 8'(f1));
            wr(3'd4, 8'(f2));
            rd(3'd2, f0, "R6 pending0");
            rd(3'd4, f2, "R6 pending2");
            w = $urandom % 7;
            repeat (w) tick();
            if (ok) begin
                ar = '{f0 + 1, f1 + 1, f2 + 1};
                go_hit = 1'b1;
                mtag = "R7";
            end else begin
                mtag = "R5";
            end
            wr(3'd5, 8'd1);
            chk(ok ? "R7 go accepted" : "R5 go rejected", int'(reject), int'(!ok));
            chk(ok ? "R7 bridge pulse" : "R5 no bridge pulse", int'(brst), int'(ok));
            repeat (40) tick();
        end
        chk("R2 still running", int'(pll_en), 1);
        trk = 1'b0;
        summary();
        $finish;
    end
endmodule